// File: doc/BRIEF.md
# Mode-Filtered Performance Counter Bank

This block holds four 32-bit event counters for a processor core. Each counter is paired with a control word. The control word picks one event input by number, names the privilege states in which the counter may advance, and enables that counter's overflow interrupt. Software reaches all eight registers through a small read/write port. Reads return their data one clock after the request.

The core supplies its current privilege state on every cycle: a two-bit mode field, an exception-level flag and an error-level flag. A counter advances by one on each clock where its selected event is high and its enable bits admit the present state. Event 0 is the clock itself and event 1 is the retired-instruction pulse. Higher event numbers come from one of two pulse vectors, and which vector a counter uses depends on whether its index is even or odd.

A counter whose top bit is set is in overflow. If its interrupt enable is on, the bank raises its interrupt and sets a pending bit in a cause-style status word. Bit 31 of each control word is wired to show whether another counter follows, so software can find out how many counters exist.

Top module: `perf_counter_bank`

## Requirements
- R1: A control register stores bits 14:0 as written: bit 0 exception-level enable, bit 1 kernel enable, bit 2 supervisor enable, bit 3 user enable, bit 4 interrupt enable, bits 14:5 event number. Bits 30:15 read as 0.
- R2: Bit 31 of a control read is a fixed "another counter follows" flag. It reads 1 for controls 0, 1 and 2 and 0 for control 3, including straight after reset.
- R3: Register address (3 bits): even address 2k selects control k, odd address 2k+1 selects counter k. Read data appears on the clock after the read request and holds until the next read.
- R4: A counter write loads the written value. A write takes priority over an increment in the same cycle.
- R5: Event 0 counts every qualified clock, and event 1 counts qualified cycles with the retire input high. Both work on all four counters.
- R6: For event numbers 2 to 127, counters 0 and 2 count the bit of that number in the even-event vector, and counters 1 and 3 count it in the odd-event vector. Event numbers of 128 and above never count.
- R7: When the exception-level or error-level flag is high, counting is allowed only by enable bit 0. Otherwise the mode field decides: 00 uses bit 1, 01 uses bit 2, 10 uses bit 3, and 11 allows no counting.
- R8: With control bits 4:0 all zero, a counter holds its value and raises no interrupt. Restoring the bits resumes counting from the held value.
- R9: The interrupt output is high when any counter has bit 31 set and its interrupt enable on. Status output bit 26 shows the same pending state, and all other status bits read 0.
- R10: A counter keeps incrementing past bit 31 and wraps from all-ones to zero. Its interrupt stays asserted until a write clears bit 31, the wrap clears it, or the interrupt enable is cleared.
- R11: A synchronous active-low reset clears every control and counter register and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register select: even for control, odd for counter |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Read request |
| reg_rd_data | output | 32 | Read data, registered |
| priv_ksu | input | 2 | Current privilege mode field |
| priv_exl | input | 1 | Exception-level flag |
| priv_erl | input | 1 | Error-level flag |
| evt_retire | input | 1 | Instruction retired this cycle |
| evt_even | input | 128 | Event pulses for counters 0 and 2 |
| evt_odd | input | 128 | Event pulses for counters 1 and 3 |
| ovf_irq | output | 1 | Overflow interrupt |
| cause_out | output | 32 | Status word, bit 26 shows an overflow interrupt is pending |

## Verification
The bench tries every combination of mode field, exception and error flag, and four enable bits on every counter. A qualification that lets the mode field win over the exception flag, or that counts in the reserved mode, shows up as a wrong count. It sweeps event numbers across and past the 128 boundary with pulses on the even vector first and then the odd vector. Swapped parity routing, or counting on out-of-range numbers, gives counts of 2 instead of 3 or a nonzero result. The overflow sequence steps a counter across bit 31, pauses it, resumes it, wraps it and clears it. A design that raises the interrupt on wrap, keeps it while paused, or lets an increment beat a same-cycle write fails there.

// File: rtl/pcb_pkg.sv
// Shared field positions and mode encodings for the performance counter bank.
// Assumes 32-bit register data and a 15-bit stored control field.
package pcb_pkg;
    localparam int CTL_EXL_EN   = 0;
    localparam int CTL_KER_EN   = 1;
    localparam int CTL_SUP_EN   = 2;
    localparam int CTL_USR_EN   = 3;
    localparam int CTL_IRQ_EN   = 4;
    localparam int CTL_EVT_LSB  = 5;
    localparam int CTL_EVT_W    = 10;
    localparam int CTL_STORED_W = CTL_EVT_LSB + CTL_EVT_W;
    localparam int CTL_GATE_W   = CTL_IRQ_EN + 1;
    localparam int CTL_MORE_BIT = 31;
    localparam int CAUSE_PEND_BIT = 26;

    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'b00,
        PRIV_SUPER  = 2'b01,
        PRIV_USER   = 2'b10,
        PRIV_NONE   = 2'b11
    } priv_mode_e;
endpackage

// File: rtl/pcb_mode_qual.sv
// Turns the core privilege state into a one-hot vector aligned with control
// bits 3:0. The exception and error flags override the mode field.
// Assumes the flags and mode field are stable for the whole cycle.
module pcb_mode_qual
    import pcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] priv_ksu,
    input  logic       priv_exl,
    input  logic       priv_erl,
    output logic [3:0] mode_active
);
    // Pick the single enable bit that matches the present privilege state.
    always_comb begin
        mode_active = '0;
        if (priv_exl || priv_erl) begin
            mode_active[CTL_EXL_EN] = 1'b1;
        end else begin
            case (priv_mode_e'(priv_ksu))
                PRIV_KERNEL: mode_active[CTL_KER_EN] = 1'b1;
                PRIV_SUPER:  mode_active[CTL_SUP_EN] = 1'b1;
                PRIV_USER:   mode_active[CTL_USR_EN] = 1'b1;
                default:     mode_active = '0;
            endcase
        end
    end

    AST_EXC_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_exl || priv_erl) |-> (mode_active == 4'b0001)); // R7
    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_active)); // R7
endmodule

// File: rtl/pcb_event_sel.sv
// Selects one event pulse by number: 0 is every cycle, 1 is instruction
// retire, 2..NUM_EVT-1 index the given vector, and anything above is silent.
// Assumes NUM_EVT is a power of two no larger than 2**SEL_W.
module pcb_event_sel #(
    parameter int NUM_EVT = 128,
    parameter int SEL_W   = 10
) (
    input  logic [SEL_W-1:0]   evt_num,
    input  logic [NUM_EVT-1:0] evt_vec,
    input  logic               evt_retire,
    output logic               evt_hit
);
    localparam int IDX_W = $clog2(NUM_EVT);
    localparam logic [SEL_W:0] EVT_LIMIT = (SEL_W+1)'(NUM_EVT);

    // Decode the event number into the selected pulse.
    always_comb begin
        if (evt_num == '0)
            evt_hit = 1'b1;
        else if (evt_num == SEL_W'(1))
            evt_hit = evt_retire;
        else if ({1'b0, evt_num} < EVT_LIMIT)
            evt_hit = evt_vec[evt_num[IDX_W-1:0]];
        else
            evt_hit = 1'b0;
    end
endmodule

// File: rtl/pcb_counter_slice.sv
// One counter with its control word: holds the stored control field, counts
// the selected event when the privilege state is enabled, and requests an
// interrupt while its top bit and interrupt enable are both set.
// Assumes a counter write and a count in the same cycle resolve to the write.
module pcb_counter_slice
    import pcb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_EVT = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_we,
    input  logic                    cnt_we,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [3:0]              mode_active,
    input  logic [NUM_EVT-1:0]      evt_vec,
    input  logic                    evt_retire,
    output logic [CTL_STORED_W-1:0] ctl_q,
    output logic [DATA_W-1:0]       cnt_q,
    output logic                    irq_req
);
    logic evt_hit;
    logic mode_ok;
    logic cnt_inc;

    pcb_event_sel #(.NUM_EVT(NUM_EVT), .SEL_W(CTL_EVT_W)) u_evt_sel (
        .evt_num    (ctl_q[CTL_EVT_LSB +: CTL_EVT_W]),
        .evt_vec    (evt_vec),
        .evt_retire (evt_retire),
        .evt_hit    (evt_hit)
    );

    // Gate the event with the enable bit of the active privilege state.
    always_comb begin
        mode_ok = |(ctl_q[3:0] & mode_active);
        cnt_inc = mode_ok && evt_hit;
        irq_req = ctl_q[CTL_IRQ_EN] && cnt_q[DATA_W-1];
    end

    // Control storage, written whole from the low bits of the data word.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= wr_data[CTL_STORED_W-1:0];
    end

    // Counter: a write loads the value, otherwise a qualified event adds one.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_we)  cnt_q <= wr_data;
        else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_q == $past(wr_data))); // R4
    AST_PAUSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && ctl_q[CTL_GATE_W-1:0] == '0) |=> $stable(cnt_q)); // R8
    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R10
    AST_HIGH_EVT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[CTL_EVT_LSB +: CTL_EVT_W] >= CTL_EVT_W'(NUM_EVT)) |-> !evt_hit); // R6
endmodule

// File: rtl/perf_counter_bank.sv
// Bank of NUM_CTR mode-filtered event counters behind a small register port.
// Even counters see evt_even, odd counters see evt_odd. Read data is registered.
// Assumes NUM_CTR is a power of two of at least 2 and DATA_W is 32.
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int DATA_W  = 32,
    parameter int NUM_EVT = 128,
    parameter int ADDR_W  = $clog2(NUM_CTR) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr_en,
    input  logic [DATA_W-1:0]  reg_wr_data,
    input  logic               reg_rd_en,
    output logic [DATA_W-1:0]  reg_rd_data,
    input  logic [1:0]         priv_ksu,
    input  logic               priv_exl,
    input  logic               priv_erl,
    input  logic               evt_retire,
    input  logic [NUM_EVT-1:0] evt_even,
    input  logic [NUM_EVT-1:0] evt_odd,
    output logic               ovf_irq,
    output logic [DATA_W-1:0]  cause_out
);
    localparam int IDX_W = ADDR_W - 1;
    localparam logic [IDX_W-1:0]  LAST_IDX      = IDX_W'(NUM_CTR - 1);
    localparam logic [ADDR_W-1:0] LAST_CTL_ADDR = {LAST_IDX, 1'b0};

    logic [3:0]              mode_active;
    logic [CTL_STORED_W-1:0] ctl_all [NUM_CTR];
    logic [DATA_W-1:0]       cnt_all [NUM_CTR];
    logic [NUM_CTR-1:0]      irq_vec;
    logic [IDX_W-1:0]        sel_idx;
    logic [DATA_W-1:0]       rd_word;

    assign sel_idx = reg_addr[ADDR_W-1:1];

    pcb_mode_qual u_mode_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .priv_ksu    (priv_ksu),
        .priv_exl    (priv_exl),
        .priv_erl    (priv_erl),
        .mode_active (mode_active)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic                 ctl_we;
        logic                 cnt_we;
        logic [NUM_EVT-1:0]   evt_src;

        // Route the parity-specific event vector to this counter.
        if (i % 2 == 0) begin : g_even
            assign evt_src = evt_even;
        end else begin : g_odd
            assign evt_src = evt_odd;
        end

        // Decode writes aimed at this counter's control or count register.
        always_comb begin
            ctl_we = reg_wr_en && !reg_addr[0] && (sel_idx == IDX_W'(i));
            cnt_we = reg_wr_en &&  reg_addr[0] && (sel_idx == IDX_W'(i));
        end

        pcb_counter_slice #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctl_we      (ctl_we),
            .cnt_we      (cnt_we),
            .wr_data     (reg_wr_data),
            .mode_active (mode_active),
            .evt_vec     (evt_src),
            .evt_retire  (evt_retire),
            .ctl_q       (ctl_all[i]),
            .cnt_q       (cnt_all[i]),
            .irq_req     (irq_vec[i])
        );
    end

    // Assemble the addressed register; the follow-on flag is fixed wiring.
    always_comb begin
        rd_word = '0;
        if (reg_addr[0]) begin
            rd_word = cnt_all[sel_idx];
        end else begin
            rd_word[CTL_STORED_W-1:0] = ctl_all[sel_idx];
            rd_word[CTL_MORE_BIT]     = (sel_idx != LAST_IDX);
        end
    end

    // Register the read data one clock after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)         reg_rd_data <= '0;
        else if (reg_rd_en) reg_rd_data <= rd_word;
    end

    // Merge the per-counter requests into the interrupt and status bit.
    always_comb begin
        ovf_irq   = |irq_vec;
        cause_out = '0;
        cause_out[CAUSE_PEND_BIT] = ovf_irq;
    end

    AST_LAST_MORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == LAST_CTL_ADDR) |=> !reg_rd_data[CTL_MORE_BIT]); // R2
    AST_RESET_QUIETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !ovf_irq); // R11
endmodule

// File: tb/perf_counter_bank_bench.sv
`timescale 1ns/1ps
module perf_counter_bank_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic         reg_wr_en = 1'b0;
    logic [31:0]  reg_wr_data = '0;
    logic         reg_rd_en = 1'b0;
    logic [31:0]  reg_rd_data;
    logic [1:0]   priv_ksu = 2'b11;
    logic         priv_exl = 1'b0;
    logic         priv_erl = 1'b0;
    logic         evt_retire = 1'b0;
    logic [127:0] evt_even = '0;
    logic [127:0] evt_odd = '0;
    logic         ovf_irq;
    logic [31:0]  cause_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    perf_counter_bank u_perf_counter_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
        .priv_ksu(priv_ksu), .priv_exl(priv_exl), .priv_erl(priv_erl),
        .evt_retire(evt_retire), .evt_even(evt_even), .evt_odd(evt_odd),
        .ovf_irq(ovf_irq), .cause_out(cause_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rd_data;
    endtask

    // Open a counting window of n clock edges, then freeze (reserved mode).
    task automatic window(input logic [1:0] ksu, input logic exl, input logic erl,
                          input logic [127:0] ev, input logic [127:0] od,
                          input logic ret, input int n);
        priv_ksu = ksu; priv_exl = exl; priv_erl = erl;
        evt_even = ev; evt_odd = od; evt_retire = ret;
        repeat (n) @(negedge clk);
        priv_ksu = 2'b11; priv_exl = 1'b0; priv_erl = 1'b0;
        evt_even = '0; evt_odd = '0; evt_retire = 1'b0;
    endtask

    function automatic bit mode_allows(input logic [3:0] en, input logic [1:0] ksu,
                                       input logic exl, input logic erl);
        if (exl || erl) return en[0];
        case (ksu)
            2'b00: return en[1];
            2'b01: return en[2];
            2'b10: return en[3];
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got 0x00000000 expected 0x00000001");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 / R2: reset state and fixed follow-on flags
        check("R11 irq after reset", {31'd0, ovf_irq}, 32'd0);
        check("R9 cause after reset", cause_out, 32'd0);
        for (int i = 0; i < 4; i++) begin
            reg_read(3'(2*i), d);
            check("R2 control after reset", d, (i < 3) ? 32'h8000_0000 : 32'h0);
            reg_read(3'(2*i+1), d);
            check("R11 counter after reset", d, 32'h0);
        end

        // R1: stored control bits and zero upper bits
        reg_write(3'd4, 32'hFFFF_FFFF);
        reg_read(3'd4, d);
        check("R1 control 2 readback", d, 32'h8000_7FFF);
        reg_write(3'd6, 32'h5555_AAAA);
        reg_read(3'd6, d);
        check("R1 control 3 readback", d, 32'h0000_2AAA);
        reg_write(3'd4, 32'h0); reg_write(3'd6, 32'h0);

        // R3: decode of all counters and one-clock read latency
        for (int i = 0; i < 4; i++) reg_write(3'(2*i+1), 32'h1000_0000 * (i+1) + i);
        for (int i = 0; i < 4; i++) begin
            reg_read(3'(2*i+1), d);
            check("R3 counter decode", d, 32'h1000_0000 * (i+1) + i);
        end
        reg_read(3'd1, prev);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = 3'd3;
        #1;
        check("R3 data before edge", reg_rd_data, prev);
        @(negedge clk);
        reg_rd_en = 1'b0;
        check("R3 data after edge", reg_rd_data, 32'h2000_0001);
        @(negedge clk);
        check("R3 data holds", reg_rd_data, 32'h2000_0001);

        // R7: every privilege state against every enable pattern on every counter
        for (int i = 0; i < 4; i++)
            for (int en = 0; en < 16; en++)
                for (int st = 0; st < 16; st++) begin
                    reg_write(3'(2*i), 32'(en));
                    reg_write(3'(2*i+1), 32'h0);
                    window(st[1:0], st[2], st[3], '0, '0, 1'b0, 3);
                    reg_read(3'(2*i+1), d);
                    check("R7 mode qualification", d,
                          mode_allows(en[3:0], st[1:0], st[2], st[3]) ? 32'd3 : 32'd0);
                end

        // R5 / R6: event number sweep across the 128 boundary
        for (int i = 0; i < 4; i++)
            for (int e = 0; e < 134; e++) begin
                logic [127:0] v;
                int en_num;
                int exp;
                en_num = (e == 133) ? 1023 : e;
                v = '0;
                if (en_num < 128) v[en_num] = 1'b1;
                reg_write(3'(2*i), (32'(en_num) << 5) | 32'h2);
                reg_write(3'(2*i+1), 32'h0);
                window(2'b00, 1'b0, 1'b0, v, '0, 1'b0, 3);
                window(2'b00, 1'b0, 1'b0, '0, v, 1'b0, 2);
                if (en_num == 0) exp = 5;
                else if (en_num == 1 || en_num >= 128) exp = 0;
                else exp = (i % 2 == 0) ? 3 : 2;
                reg_read(3'(2*i+1), d);
                check((en_num < 2) ? "R5 event sweep" : "R6 event sweep", d, 32'(exp));
            end

        // R5: retire event counts only retire pulses, on all counters
        for (int i = 0; i < 4; i++) begin
            reg_write(3'(2*i), (32'd1 << 5) | 32'h2);
            reg_write(3'(2*i+1), 32'h0);
            window(2'b00, 1'b0, 1'b0, '1, '1, 1'b1, 4);
            window(2'b00, 1'b0, 1'b0, '1, '1, 1'b0, 3);
            reg_read(3'(2*i+1), d);
            check("R5 retire event", d, 32'd4);
        end

        // R4: write beats a same-cycle increment
        reg_write(3'd0, 32'h2);
        reg_write(3'd1, 32'h0);
        priv_ksu = 2'b00;
        reg_write(3'd1, 32'd100);
        priv_ksu = 2'b11;
        reg_read(3'd1, d);
        check("R4 write wins", d, 32'd100);

        // R9 / R8 / R10: overflow sequence on counter 1
        reg_write(3'd2, 32'h12);
        reg_write(3'd3, 32'h7FFF_FFFE);
        window(2'b00, 1'b0, 1'b0, '0, '0, 1'b0, 1);
        check("R9 no irq below bit 31", {31'd0, ovf_irq}, 32'd0);
        window(2'b00, 1'b0, 1'b0, '0, '0, 1'b0, 1);
        check("R9 irq at bit 31", {31'd0, ovf_irq}, 32'd1);
        check("R9 cause bit 26", cause_out, 32'h0400_0000);
        reg_write(3'd2, 32'h0);
        check("R8 paused irq off", {31'd0, ovf_irq}, 32'd0);
        check("R8 paused cause", cause_out, 32'h0);
        window(2'b00, 1'b0, 1'b0, '0, '0, 1'b0, 3);
        reg_read(3'd3, d);
        check("R8 paused holds", d, 32'h8000_0000);
        reg_write(3'd2, 32'h12);
        check("R8 resume irq", {31'd0, ovf_irq}, 32'd1);
        window(2'b00, 1'b0, 1'b0, '0, '0, 1'b0, 2);
        reg_read(3'd3, d);
        check("R10 counts past bit 31", d, 32'h8000_0002);
        check("R10 irq stays", {31'd0, ovf_irq}, 32'd1);
        reg_write(3'd2, 32'h2);
        check("R10 irq off with enable clear", {31'd0, ovf_irq}, 32'd0);
        reg_write(3'd2, 32'h12);
        reg_write(3'd3, 32'h5);
        check("R10 irq off after clear write", {31'd0, ovf_irq}, 32'd0);
        reg_write(3'd3, 32'hFFFF_FFFF);
        check("R10 irq at all ones", {31'd0, ovf_irq}, 32'd1);
        window(2'b00, 1'b0, 1'b0, '0, '0, 1'b0, 1);
        reg_read(3'd3, d);
        check("R10 wrap value", d, 32'h0);
        check("R10 wrap clears irq", {31'd0, ovf_irq}, 32'd0);

        // R11: mid-run reset clears registers and the interrupt
        reg_write(3'd0, 32'h1F);
        reg_write(3'd1, 32'h8000_0000);
        check("R9 counter 0 irq", {31'd0, ovf_irq}, 32'd1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        check("R11 irq cleared", {31'd0, ovf_irq}, 32'd0);
        reg_read(3'd0, d);
        check("R11 control cleared", d, 32'h8000_0000);
        reg_read(3'd1, d);
        check("R11 counter cleared", d, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule